// File: doc/BRIEF.md
# Tag-Ordered Reservation Station Scheduler

This block is the scheduling queue of one out-of-order core. Each dispatched instruction arrives with a sequence tag, a class, two source operands and, for memory operations, an effective address. Each source is either already available or named by the tag of the instruction that produces it. The entry waits in a pool that belongs to its function-unit type. It listens to the completion port for the tags it depends on. Once both sources are available, it is offered to the pipelined function units of its type. When more entries are ready than there are units, the oldest ones go first.

An entry does not leave its pool when it fires. It stays until its own tag comes back on the completion port. The slot it occupied can take a new dispatch from the following cycle on. In the memory pool, a load or store that is ready can still be held back. The hold applies while an older operation on the same address is resident in the pool: a store blocks younger loads and stores, and a load blocks younger stores. Fetch, prediction, caching and the register file live outside this block and are visible here only through the completion port.

Top module: `tag_sched`

## Requirements
- R1: After a synchronous active-low reset every pool is empty: no fire output is valid and `disp_full` is low for every class.
- R2: The pool of a type has SLOTS_PER_UNIT times the number of units of that type entries. `disp_full` is high when the pool for `disp_cls` has no empty entry, and a refused dispatch is not stored. An entry freed by a completion in cycle C cannot be refilled before cycle C+1.
- R3: The `disp_cls` encoding is 0 for add or branch, which go to the ALU pool. 1 is multiply, which goes to the multiply pool. 2 is a load and 3 is a store, and both go to the memory pool.
- R4: An entry accepted in cycle J fires no earlier than cycle J+1. With both sources available it fires in cycle J+1.
- R5: A completion in cycle C marks every waiting source with that tag as available from cycle C+1. A dispatch in the same cycle as the completion of its source tag also records the source as available.
- R6: Each cycle, each pool fires at most one entry per unit of its type. The ready entries are chosen oldest tag first, and fire slot 0 carries the oldest.
- R7: An entry fires exactly once.
- R8: A fired entry stays resident, and keeps its memory-order effect, until its tag completes.
- R9: Several completions in one cycle are all applied, both to the entries they free and to the sources they wake, and they take effect in the next cycle.
- R10: A load does not fire while an older store to the same address is resident.
- R11: A store does not fire while an older load or store to the same address is resident.
- R12: Memory operations on different addresses do not block each other, and a younger operation never holds back an older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_cls | input | 2 | Instruction class (R3 encoding) |
| disp_tag | input | TAG_W | Sequence tag of the instruction |
| disp_src1_rdy | input | 1 | Source 1 already available |
| disp_src1_tag | input | TAG_W | Producer tag of source 1 when not available |
| disp_src2_rdy | input | 1 | Source 2 already available |
| disp_src2_tag | input | TAG_W | Producer tag of source 2 when not available |
| disp_addr | input | ADDR_W | Effective address of a load or store |
| disp_full | output | 1 | Pool for `disp_cls` has no free entry; dispatch refused |
| cmp_vld | input | N_CMP | Per-lane completion valid |
| cmp_tag | input | N_CMP*TAG_W | Completing tags, lane i at bits i*TAG_W |
| fire_alu_vld | output | N_ALU | Per-unit fire valid, ALU type |
| fire_alu_tag | output | N_ALU*TAG_W | Fired tags, ALU type |
| fire_mul_vld | output | N_MUL | Per-unit fire valid, multiply type |
| fire_mul_tag | output | N_MUL*TAG_W | Fired tags, multiply type |
| fire_mem_vld | output | N_MEM | Per-unit fire valid, memory type |
| fire_mem_tag | output | N_MEM*TAG_W | Fired tags, memory type |

## Verification
The assertions rely on a well-formed environment. Tags rise strictly and never wrap. Every completing tag belongs to an entry that has fired and is still resident, and each tag completes at most once. Source tags always name older instructions. The bench models the function units by hand: it reports a completion only for tags it has already seen on a fire output. It uses small tags that never approach wrap, and it never repeats a completion, so the stimulus stays inside these rules.

// File: rtl/sched_pkg.sv
// Shared definitions for the tag-ordered scheduler.
// Assumes the class encoding below is also what the dispatch stage drives.
package sched_pkg;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'd0,
        CLS_MUL   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } op_cls_e;

    localparam int unsigned POOL_ALU = 0;
    localparam int unsigned POOL_MUL = 1;
    localparam int unsigned POOL_MEM = 2;
    localparam int unsigned N_POOLS  = 3;

    // Map an instruction class to the pool index that serves it.
    function automatic logic [1:0] pool_of(input op_cls_e c);
        case (c)
            CLS_ALU: pool_of = 2'(POOL_ALU);
            CLS_MUL: pool_of = 2'(POOL_MUL);
            default: pool_of = 2'(POOL_MEM);
        endcase
    endfunction

endpackage

// File: rtl/sched_pick.sv
// Oldest-first selector: grants up to UNITS requesting entries, lowest tag
// first, and reports the granted tags in age order on the unit slots.
// Assumes requesting entries carry distinct tags.
module sched_pick #(
    parameter int DEPTH = 4,
    parameter int UNITS = 2,
    parameter int TAG_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             req,
    input  logic [DEPTH-1:0][TAG_W-1:0]  tags,
    output logic [DEPTH-1:0]             gnt,
    output logic [UNITS-1:0]             out_vld,
    output logic [UNITS-1:0][TAG_W-1:0]  out_tag
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          found;
    logic [IW-1:0] best;

    // Repeated minimum search: one pass per unit, skipping already granted entries.
    always_comb begin
        gnt     = '0;
        out_vld = '0;
        out_tag = '0;
        found   = 1'b0;
        best    = '0;
        for (int u = 0; u < UNITS; u++) begin
            found = 1'b0;
            best  = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (req[i] && !gnt[i] && (!found || tags[i] < tags[best])) begin
                    found = 1'b1;
                    best  = IW'(i);
                end
            end
            if (found) begin
                gnt[best]  = 1'b1;
                out_vld[u] = 1'b1;
                out_tag[u] = tags[best];
            end
        end
    end

    // Unit slots fill from 0 upward in strictly rising age order (R6).
    for (genvar u = 1; u < UNITS; u++) begin : g_ord
        p_oldest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[u] |-> (out_vld[u-1] && out_tag[u-1] < out_tag[u]));
    end

    // Number of granted entries matches the number of filled unit slots (R6).
    p_grant_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) == $countones(out_vld));

endmodule

// File: rtl/sched_pool.sv
// One reservation pool for one function-unit type. Holds entries from
// dispatch until their own tag completes, wakes sources on completion
// broadcasts and offers ready entries to the picker. With MEM_ORDER set,
// same-address ordering between loads and stores gates readiness.
// Assumes tags rise without wrap and completions name resident entries.
module sched_pool #(
    parameter int DEPTH     = 2,
    parameter int UNITS     = 1,
    parameter int TAG_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int N_CMP     = 4,
    parameter bit MEM_ORDER = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins,
    input  logic [TAG_W-1:0]             ins_tag,
    input  logic                         ins_s1_rdy,
    input  logic [TAG_W-1:0]             ins_s1_tag,
    input  logic                         ins_s2_rdy,
    input  logic [TAG_W-1:0]             ins_s2_tag,
    input  logic                         ins_store,
    input  logic [ADDR_W-1:0]            ins_addr,
    input  logic [N_CMP-1:0]             cmp_vld,
    input  logic [N_CMP-1:0][TAG_W-1:0]  cmp_tag,
    output logic                         full,
    output logic [UNITS-1:0]             fire_vld,
    output logic [UNITS-1:0][TAG_W-1:0]  fire_tag
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]              vld_q, fired_q, s1r_q, s2r_q, st_q;
    logic [DEPTH-1:0][TAG_W-1:0]   tag_q, s1t_q, s2t_q;
    logic [DEPTH-1:0][ADDR_W-1:0]  adr_q;
    logic [DEPTH-1:0]              done, wk1, wk2, mem_ok, req, gnt;
    logic                          ins_w1, ins_w2, any_free;
    logic [IW-1:0]                 free_idx;

    // Compare every completion lane with resident tags, waiting sources and the incoming sources.
    always_comb begin
        done   = '0;
        wk1    = '0;
        wk2    = '0;
        ins_w1 = 1'b0;
        ins_w2 = 1'b0;
        for (int c = 0; c < N_CMP; c++) begin
            if (cmp_vld[c]) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (vld_q[i] && cmp_tag[c] == tag_q[i]) done[i] = 1'b1;
                    if (cmp_tag[c] == s1t_q[i]) wk1[i] = 1'b1;
                    if (cmp_tag[c] == s2t_q[i]) wk2[i] = 1'b1;
                end
                if (cmp_tag[c] == ins_s1_tag) ins_w1 = 1'b1;
                if (cmp_tag[c] == ins_s2_tag) ins_w2 = 1'b1;
            end
        end
    end

    // Same-address ordering: an older resident store blocks all, an older load blocks stores.
    always_comb begin
        mem_ok = '1;
        if (MEM_ORDER) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j != i && vld_q[j] && tag_q[j] < tag_q[i] &&
                        adr_q[j] == adr_q[i] && (st_q[j] || st_q[i]))
                        mem_ok[i] = 1'b0;
                end
            end
        end
        req = vld_q & ~fired_q & s1r_q & s2r_q & mem_ok;
    end

    // Lowest empty slot; occupancy counts entries freed this cycle as still present.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
    assign full = !any_free;

    sched_pick #(
        .DEPTH (DEPTH),
        .UNITS (UNITS),
        .TAG_W (TAG_W)
    ) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .tags    (tag_q),
        .gnt     (gnt),
        .out_vld (fire_vld),
        .out_tag (fire_tag)
    );

    // Entry state update: free on completion, mark fired, wake sources, then insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            fired_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (done[i]) begin
                    vld_q[i] <= 1'b0;
                end else begin
                    if (gnt[i]) fired_q[i] <= 1'b1;
                    if (wk1[i]) s1r_q[i]   <= 1'b1;
                    if (wk2[i]) s2r_q[i]   <= 1'b1;
                end
            end
            if (ins && any_free) begin
                vld_q[free_idx]   <= 1'b1;
                fired_q[free_idx] <= 1'b0;
                tag_q[free_idx]   <= ins_tag;
                s1t_q[free_idx]   <= ins_s1_tag;
                s2t_q[free_idx]   <= ins_s2_tag;
                s1r_q[free_idx]   <= ins_s1_rdy | ins_w1;
                s2r_q[free_idx]   <= ins_s2_rdy | ins_w2;
                st_q[free_idx]    <= ins_store;
                adr_q[free_idx]   <= ins_addr;
            end
        end
    end

    // A full pool stays full until some resident tag completes (R2).
    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(|done)) |=> full);

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        // A broadcast on a waiting source makes it available next cycle (R5).
        p_wake_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q[i] && !done[i] && !s1r_q[i] && wk1[i]) |=> s1r_q[i]);
        // A fired entry remains resident and fired until its tag completes (R8).
        p_resident_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q[i] && fired_q[i] && !done[i]) |=> (vld_q[i] && fired_q[i]));
    end

endmodule

// File: rtl/tag_sched.sv
// Top of the scheduling queue: routes each dispatch to the pool of its
// function-unit type, fans the completion port out to all pools and
// exposes the per-type fire ports. Only the memory pool applies
// address ordering. Assumes one dispatch per cycle.
module tag_sched
    import sched_pkg::*;
#(
    parameter int N_ALU          = 3,
    parameter int N_MUL          = 1,
    parameter int N_MEM          = 2,
    parameter int SLOTS_PER_UNIT = 1,
    parameter int TAG_W          = 16,
    parameter int ADDR_W         = 32,
    parameter int N_CMP          = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [1:0]               disp_cls,
    input  logic [TAG_W-1:0]         disp_tag,
    input  logic                     disp_src1_rdy,
    input  logic [TAG_W-1:0]         disp_src1_tag,
    input  logic                     disp_src2_rdy,
    input  logic [TAG_W-1:0]         disp_src2_tag,
    input  logic [ADDR_W-1:0]        disp_addr,
    output logic                     disp_full,
    input  logic [N_CMP-1:0]         cmp_vld,
    input  logic [N_CMP*TAG_W-1:0]   cmp_tag,
    output logic [N_ALU-1:0]         fire_alu_vld,
    output logic [N_ALU*TAG_W-1:0]   fire_alu_tag,
    output logic [N_MUL-1:0]         fire_mul_vld,
    output logic [N_MUL*TAG_W-1:0]   fire_mul_tag,
    output logic [N_MEM-1:0]         fire_mem_vld,
    output logic [N_MEM*TAG_W-1:0]   fire_mem_tag
);
    op_cls_e                        cls;
    logic [1:0]                     sel;
    logic [N_POOLS-1:0]             pool_full;
    logic [N_CMP-1:0][TAG_W-1:0]    cmp_lanes;

    assign cls       = op_cls_e'(disp_cls);
    assign sel       = pool_of(cls);
    assign cmp_lanes = cmp_tag;
    assign disp_full = pool_full[sel];

    for (genvar p = 0; p < N_POOLS; p++) begin : g_pool
        localparam int UP = (p == POOL_ALU) ? N_ALU : (p == POOL_MUL) ? N_MUL : N_MEM;
        logic                   ins_p;
        logic [UP-1:0]          fv;
        logic [UP-1:0][TAG_W-1:0] ft;

        assign ins_p = disp_valid && !disp_full && (sel == 2'(p));

        sched_pool #(
            .DEPTH     (UP * SLOTS_PER_UNIT),
            .UNITS     (UP),
            .TAG_W     (TAG_W),
            .ADDR_W    (ADDR_W),
            .N_CMP     (N_CMP),
            .MEM_ORDER (p == POOL_MEM)
        ) i_pool (
            .clk        (clk),
            .rst_n      (rst_n),
            .ins        (ins_p),
            .ins_tag    (disp_tag),
            .ins_s1_rdy (disp_src1_rdy),
            .ins_s1_tag (disp_src1_tag),
            .ins_s2_rdy (disp_src2_rdy),
            .ins_s2_tag (disp_src2_tag),
            .ins_store  (cls == CLS_STORE),
            .ins_addr   (disp_addr),
            .cmp_vld    (cmp_vld),
            .cmp_tag    (cmp_lanes),
            .full       (pool_full[p]),
            .fire_vld   (fv),
            .fire_tag   (ft)
        );

        if (p == POOL_ALU) begin : g_alu
            assign fire_alu_vld = fv;
            assign fire_alu_tag = ft;
        end else if (p == POOL_MUL) begin : g_mul
            assign fire_mul_vld = fv;
            assign fire_mul_tag = ft;
        end else begin : g_mem
            assign fire_mem_vld = fv;
            assign fire_mem_tag = ft;
        end
    end

    // The cycle after a reset edge shows no fire on any type (R1).
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (fire_alu_vld == '0 && fire_mul_vld == '0 && fire_mem_vld == '0));

    // The oldest ALU slot never presents the same tag on two consecutive cycles (R7).
    p_no_refire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fire_alu_vld[0] && $past(fire_alu_vld[0]))
            |-> fire_alu_tag[TAG_W-1:0] != $past(fire_alu_tag[TAG_W-1:0]));

endmodule

// File: tb/test_tag_sched.sv
module test_tag_sched;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;

    typedef struct packed {
        logic       dv;
        logic [1:0] cls;
        logic [7:0] tg;
        logic       s1r;
        logic [7:0] s1t;
        logic [1:0] cv;
        logic [7:0] c0;
        logic [7:0] c1;
        logic       xfull;
        logic [1:0] xn0;
        logic [7:0] xt0;
        logic       xv1;
        logic [7:0] xt1;
    } row_t;

    // Each row: inputs for one cycle and the outputs expected in that cycle (state from before its edge).
    localparam row_t TBL [15] = '{
        '{1'b1, 2'd0, 8'd0, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b1, 2'd1, 8'd1, 1'b0, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd1, 8'd0, 1'b0, 8'd0},
        '{1'b1, 2'd0, 8'd2, 1'b0, 8'd1, 2'd1, 8'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b1, 2'd0, 8'd3, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b1, 8'd1},
        '{1'b1, 2'd0, 8'd4, 1'b0, 8'd3, 2'd0, 8'd0, 8'd0, 1'b0, 2'd1, 8'd3, 1'b0, 8'd0},
        '{1'b0, 2'd0, 8'd0, 1'b1, 8'd0, 2'd3, 8'd3, 8'd1, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b0, 2'd0, 8'd0, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd2, 8'd2, 1'b0, 8'd0},
        '{1'b1, 2'd1, 8'd5, 1'b1, 8'd0, 2'd3, 8'd2, 8'd4, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b1, 2'd1, 8'd6, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b1, 8'd5},
        '{1'b1, 2'd1, 8'd7, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b1, 8'd6},
        '{1'b1, 2'd1, 8'd7, 1'b1, 8'd0, 2'd1, 8'd5, 8'd0, 1'b1, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b1, 2'd1, 8'd7, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b0, 2'd1, 8'd0, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b1, 2'd0, 8'd0, 1'b1, 8'd7},
        '{1'b1, 2'd0, 8'd8, 1'b0, 8'd7, 2'd3, 8'd7, 8'd6, 1'b0, 2'd0, 8'd0, 1'b0, 8'd0},
        '{1'b0, 2'd0, 8'd0, 1'b1, 8'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd1, 8'd8, 1'b0, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disp_valid;
    logic [1:0]    disp_cls;
    logic [TW-1:0] disp_tag, s1_tag, s2_tag;
    logic          s1_rdy, s2_rdy;
    logic [31:0]   disp_addr;
    logic          disp_full;
    logic [3:0]    cmp_vld;
    logic [4*TW-1:0] cmp_tag;
    logic [2:0]    fire_alu_vld;
    logic [3*TW-1:0] fire_alu_tag;
    logic [0:0]    fire_mul_vld;
    logic [TW-1:0] fire_mul_tag;
    logic [1:0]    fire_mem_vld;
    logic [2*TW-1:0] fire_mem_tag;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tag_sched #(
        .N_ALU (3), .N_MUL (1), .N_MEM (2), .SLOTS_PER_UNIT (2),
        .TAG_W (TW), .ADDR_W (32), .N_CMP (4)
    ) i_tag_sched (
        .clk (clk), .rst_n (rst_n),
        .disp_valid (disp_valid), .disp_cls (disp_cls), .disp_tag (disp_tag),
        .disp_src1_rdy (s1_rdy), .disp_src1_tag (s1_tag),
        .disp_src2_rdy (s2_rdy), .disp_src2_tag (s2_tag),
        .disp_addr (disp_addr), .disp_full (disp_full),
        .cmp_vld (cmp_vld), .cmp_tag (cmp_tag),
        .fire_alu_vld (fire_alu_vld), .fire_alu_tag (fire_alu_tag),
        .fire_mul_vld (fire_mul_vld), .fire_mul_tag (fire_mul_tag),
        .fire_mem_vld (fire_mem_vld), .fire_mem_tag (fire_mem_tag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        disp_valid = 1'b0; disp_cls = 2'd0; disp_tag = '0;
        s1_rdy = 1'b1; s1_tag = '0; s2_rdy = 1'b1; s2_tag = '0;
        disp_addr = '0; cmp_vld = '0; cmp_tag = '0;
    endtask

    task automatic disp(input logic [1:0] c, input int t, input logic r1, input int t1, input int a);
        disp_valid = 1'b1; disp_cls = c; disp_tag = TW'(t);
        s1_rdy = r1; s1_tag = TW'(t1); disp_addr = 32'(a);
    endtask

    task automatic cmp(input int lane, input int t);
        cmp_vld[lane] = 1'b1;
        cmp_tag[lane*TW +: TW] = TW'(t);
    endtask

    task automatic next_cycle();
        @(negedge clk);
        clr();
    endtask

    task automatic do_reset();
        next_cycle();
        rst_n = 1'b0;
        next_cycle();
        next_cycle();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is a failed check and still reports the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_err++; n_chk++;
                $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        clr();
        rst_n = 1'b0;
        do_reset();

        // Reset state, all classes.
        next_cycle();
        #1;
        chk("R1", "alu fire", 32'(fire_alu_vld), 0);
        chk("R1", "mul fire", 32'(fire_mul_vld), 0);
        chk("R1", "mem fire", 32'(fire_mem_vld), 0);
        for (int c = 0; c < 4; c++) begin
            disp_cls = 2'(c);
            #1 chk("R1", "full per class", 32'(disp_full), 0);
        end

        // Table walk: dependency chains through ALU and MUL pools, capacity and wakeup timing.
        for (int k = 0; k < 15; k++) begin
            next_cycle();
            disp_valid = TBL[k].dv; disp_cls = TBL[k].cls; disp_tag = TW'(TBL[k].tg);
            s1_rdy = TBL[k].s1r; s1_tag = TW'(TBL[k].s1t);
            cmp_vld = {2'b00, TBL[k].cv};
            cmp_tag = {32'd0, 8'd0, TBL[k].c1, 8'd0, TBL[k].c0};
            #1;
            chk("R2", $sformatf("row %0d full", k), 32'(disp_full), 32'(TBL[k].xfull));
            chk("R4,R5,R7,R9", $sformatf("row %0d alu count", k),
                32'($countones(fire_alu_vld)), 32'(TBL[k].xn0));
            if (TBL[k].xn0 != 0)
                chk("R6", $sformatf("row %0d alu oldest", k), 32'(fire_alu_tag[TW-1:0]), 32'(TBL[k].xt0));
            chk("R3,R5", $sformatf("row %0d mul valid", k), 32'(fire_mul_vld), 32'(TBL[k].xv1));
            if (TBL[k].xv1)
                chk("R3", $sformatf("row %0d mul tag", k), 32'(fire_mul_tag), 32'(TBL[k].xt1));
        end

        // Oldest-first selection over more ready entries than units.
        do_reset();
        for (int t = 20; t < 24; t++) begin
            next_cycle();
            disp(2'd0, t, 1'b0, 30, 0);
        end
        next_cycle();
        cmp(0, 30);
        #1 chk("R6", "alu idle before wake", 32'($countones(fire_alu_vld)), 0);
        next_cycle();
        #1;
        chk("R6", "alu count limited to units", 32'($countones(fire_alu_vld)), 3);
        chk("R6", "unit0 tag", 32'(fire_alu_tag[0*TW +: TW]), 20);
        chk("R6", "unit1 tag", 32'(fire_alu_tag[1*TW +: TW]), 21);
        chk("R6", "unit2 tag", 32'(fire_alu_tag[2*TW +: TW]), 22);
        next_cycle();
        #1;
        chk("R6", "leftover count", 32'($countones(fire_alu_vld)), 1);
        chk("R6", "leftover tag", 32'(fire_alu_tag[TW-1:0]), 23);
        next_cycle();
        #1 chk("R7", "no refire", 32'($countones(fire_alu_vld)), 0);

        // Load behind an older same-address store; unrelated load passes.
        do_reset();
        next_cycle(); disp(2'd3, 40, 1'b0, 99, 'h100);
        next_cycle(); disp(2'd2, 41, 1'b1, 0, 'h100);
        next_cycle(); disp(2'd2, 42, 1'b1, 0, 'h200);
        #1 chk("R10", "nothing ready", 32'(fire_mem_vld), 0);
        next_cycle(); cmp(0, 99);
        #1;
        chk("R12", "other address fires", 32'($countones(fire_mem_vld)), 1);
        chk("R10,R12", "fired tag", 32'(fire_mem_tag[TW-1:0]), 42);
        next_cycle(); cmp(0, 42);
        #1;
        chk("R12", "older store not held by younger load", 32'($countones(fire_mem_vld)), 1);
        chk("R12", "store tag", 32'(fire_mem_tag[TW-1:0]), 40);
        next_cycle(); cmp(0, 40);
        #1 chk("R8,R10", "load held while fired store resident", 32'(fire_mem_vld), 0);
        next_cycle();
        #1;
        chk("R10", "load after store completes", 32'($countones(fire_mem_vld)), 1);
        chk("R10", "load tag", 32'(fire_mem_tag[TW-1:0]), 41);

        // Store behind an older same-address load.
        do_reset();
        next_cycle(); disp(2'd2, 50, 1'b0, 99, 'h300);
        next_cycle(); disp(2'd3, 51, 1'b1, 0, 'h300);
        next_cycle(); cmp(0, 99);
        #1 chk("R11", "store held by older load", 32'(fire_mem_vld), 0);
        next_cycle();
        #1;
        chk("R11", "load fires", 32'($countones(fire_mem_vld)), 1);
        chk("R11", "load tag", 32'(fire_mem_tag[TW-1:0]), 50);
        next_cycle(); cmp(0, 50);
        #1 chk("R8,R11", "store held while load resident", 32'(fire_mem_vld), 0);
        next_cycle();
        #1;
        chk("R11", "store fires after load completes", 32'($countones(fire_mem_vld)), 1);
        chk("R11", "store tag", 32'(fire_mem_tag[TW-1:0]), 51);

        // Reset in the middle of activity empties all pools.
        next_cycle(); disp(2'd2, 60, 1'b1, 0, 'h400);
        next_cycle(); disp(2'd2, 61, 1'b1, 0, 'h500);
        do_reset();
        next_cycle();
        disp_cls = 2'd3;
        #1;
        chk("R1", "mem fire after reset", 32'(fire_mem_vld), 0);
        chk("R1", "mem full after reset", 32'(disp_full), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule